// File: doc/BRIEF.md
# DSP Effective Address Generator

This block works out the effective address of one data-memory access in a 24-bit address space. Each cycle that `req_vld` is high it takes an addressing-mode code, the selected pointer register, the offset register, the stack pointer and the address or displacement field from the instruction word. One clock later it presents the effective address, the new pointer value and a write-back enable.

The update modes use the pointer's old value as the address and return the advanced pointer through `ptr_nxt`. The indexed modes add a displacement to the pointer or to the stack pointer. The displacement may be unsigned, forced negative or sign-extended, depending on the mode. The absolute modes turn an instruction field into an address without adding anything to it. The block does no instruction decoding and holds no register file, so the caller writes `ptr_nxt` back when `ptr_we` is high. All sums wrap modulo 2^24.

Top module: `dsp_eagen`

## Requirements
- R1: While reset is asserted, and until the first request after it, `res_vld`, `ptr_we`, `ea` and `ptr_nxt` are all zero.
- R2: Mode 0 (plain indirect) gives `ea` = `ptr`, `ptr_nxt` = `ptr` and `ptr_we` = 0.
- R3: Mode 1 (post-increment) and mode 2 (post-decrement) give `ea` = `ptr`, `ptr_nxt` = `ptr` + 1 or `ptr` - 1 modulo 2^24, and `ptr_we` = 1.
- R4: Mode 3 (post-update by offset register) gives `ea` = `ptr`, `ptr_nxt` = `ptr` + `nreg` modulo 2^24, and `ptr_we` = 1.
- R5: Mode 4 gives `ea` = `ptr` + `imm[2:0]`, with the field taken unsigned (0 to 7). `ptr_we` = 0 and `ptr_nxt` = `ptr`.
- R6: Mode 5 gives `ea` = `sp` - 8 + `imm[2:0]`, an offset from -8 (field 0) to -1 (field 7), modulo 2^24. `ptr_we` = 0.
- R7: Mode 6 gives `ea` = `sp` - 64 + `imm[5:0]`, an offset from -64 (field 0) to -1 (field 63), modulo 2^24. `ptr_we` = 0.
- R8: Mode 7 gives `ea` = `ptr` + `imm[15:0]`, with the field sign-extended from bit 15, modulo 2^24. `ptr_we` = 0.
- R9: Mode 8 gives `ea` = `ptr` + `imm[23:0]` modulo 2^24. `ptr_we` = 0.
- R10: Mode 9 gives `ea` = `imm[5:0]`, mode 11 gives `ea` = `imm[15:0]` (both zero-extended) and mode 12 gives `ea` = `imm`. The higher `imm` bits have no effect, and `ptr_we` = 0.
- R11: Mode 10 (short peripheral) gives `ea` = 0x1FFFC0 + `imm[5:0]`, so that `ea[23:6]` is always 0x7FFF. `ptr_we` = 0.
- R12: A request on one rising edge gives `res_vld` = 1 and its results after that edge. In a cycle with no request, `res_vld` = 0 and `ea`, `ptr_nxt` and `ptr_we` keep their values.
- R13: Mode codes 13 to 15 give `ea` = `ptr`, `ptr_nxt` = `ptr` and `ptr_we` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe; also the result clock enable |
| mode | input | 4 | Addressing-mode code |
| ptr | input | 24 | Selected pointer register |
| nreg | input | 24 | Offset register for post-update |
| sp | input | 24 | Stack pointer |
| imm | input | 24 | Address or displacement field from the instruction |
| res_vld | output | 1 | Result valid, one cycle after the request |
| ea | output | 24 | Effective address |
| ptr_nxt | output | 24 | Post-updated pointer |
| ptr_we | output | 1 | Write-back enable for `ptr_nxt` |

## Verification
The bench targets the wrap points. It runs post-increment from 0xFFFFFF, post-decrement from 0, and a stack pointer near zero with the largest negative offsets; a design that kept a carry or lost a borrow would give an address outside 24 bits or one that is off by a page. The stack-relative modes are driven with field values 0 and all-ones, and the 16-bit displacement with 0x7FFF and 0x8000. A design that took the field as positive, or sign-extended from the wrong bit, would point the access past the stack pointer or far from the pointer. The absolute and peripheral forms are driven with `imm` bits set above their field, which shows up any design that does not mask those bits. Idle cycles and the unused mode codes show whether the design holds its results and whether it raises a pointer write that no instruction asked for.

// File: rtl/dsp_eagen_pkg.sv
package dsp_eagen_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IND    = 4'd0,
    AM_PINC   = 4'd1,
    AM_PDEC   = 4'd2,
    AM_PUPN   = 4'd3,
    AM_D3PTR  = 4'd4,
    AM_D3SP   = 4'd5,
    AM_D6SP   = 4'd6,
    AM_D16    = 4'd7,
    AM_D24    = 4'd8,
    AM_ABS6   = 4'd9,
    AM_IOSHRT = 4'd10,
    AM_ABS16  = 4'd11,
    AM_ABS24  = 4'd12
  } amode_e;

endpackage

// File: rtl/dsp_eagen_opsel.sv
// Chooses the two adder operands for the effective address.
module dsp_eagen_opsel
  import dsp_eagen_pkg::*;
#(
  parameter int          AW      = 24,
  parameter int          SD_W    = 3,
  parameter int          SPL_W   = 6,
  parameter int          MD_W    = 16,
  parameter logic [23:0] IO_BASE = 24'h1FFFC0
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     ptr,
  input  logic [AW-1:0]     sp,
  input  logic [AW-1:0]     imm,
  output logic [AW-1:0]     opa,
  output logic [AW-1:0]     opb
);

  localparam logic [AW-1:0] ZERO = '0;
  localparam logic [AW-1:0] IOB  = IO_BASE[AW-1:0];

  logic [AW-1:0] short_u;
  logic [AW-1:0] short_neg;
  logic [AW-1:0] long_neg;
  logic [AW-1:0] mid_sx;
  logic [AW-1:0] mid_zx;
  logic [AW-1:0] abs_zx;

  // Forced-negative forms: prefix the field with ones, giving -2^W .. -1.
  assign short_u   = {{(AW-SD_W){1'b0}}, imm[SD_W-1:0]};
  assign short_neg = {{(AW-SD_W){1'b1}}, imm[SD_W-1:0]};
  assign long_neg  = {{(AW-SPL_W){1'b1}}, imm[SPL_W-1:0]};
  assign mid_sx    = {{(AW-MD_W){imm[MD_W-1]}}, imm[MD_W-1:0]};
  assign mid_zx    = {{(AW-MD_W){1'b0}}, imm[MD_W-1:0]};
  assign abs_zx    = {{(AW-SPL_W){1'b0}}, imm[SPL_W-1:0]};

  always_comb begin
    opa = ptr;
    opb = ZERO;
    case (amode_e'(mode))
      AM_D3PTR:  begin opa = ptr;  opb = short_u;   end
      AM_D3SP:   begin opa = sp;   opb = short_neg; end
      AM_D6SP:   begin opa = sp;   opb = long_neg;  end
      AM_D16:    begin opa = ptr;  opb = mid_sx;    end
      AM_D24:    begin opa = ptr;  opb = imm;       end
      AM_ABS6:   begin opa = ZERO; opb = abs_zx;    end
      AM_IOSHRT: begin opa = IOB;  opb = abs_zx;    end
      AM_ABS16:  begin opa = ZERO; opb = mid_zx;    end
      AM_ABS24:  begin opa = ZERO; opb = imm;       end
      default:   begin opa = ptr;  opb = ZERO;      end
    endcase
  end

endmodule

// File: rtl/dsp_eagen_postupd.sv
// Computes the post-modified pointer and its write-back enable.
module dsp_eagen_postupd
  import dsp_eagen_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     ptr,
  input  logic [AW-1:0]     nreg,
  output logic [AW-1:0]     nxt,
  output logic              we
);

  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] MONE = '1;

  logic [AW-1:0] step;

  always_comb begin
    step = '0;
    we   = 1'b0;
    case (amode_e'(mode))
      AM_PINC: begin step = ONE;  we = 1'b1; end
      AM_PDEC: begin step = MONE; we = 1'b1; end
      AM_PUPN: begin step = nreg; we = 1'b1; end
      default: begin step = '0;   we = 1'b0; end
    endcase
  end

  dsp_eagen_add #(.AW(AW)) u_add (
    .a   (ptr),
    .b   (step),
    .sum (nxt)
  );

endmodule

// File: rtl/dsp_eagen_add.sv
// Modulo-2^AW adder, split into two halves when SPLIT is set.
module dsp_eagen_add #(
  parameter int AW    = 24,
  parameter bit SPLIT = 1'b0
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] sum
);

  localparam int LO_W = AW / 2;
  localparam int HI_W = AW - LO_W;

  generate
    if (SPLIT) begin : g_split
      logic [LO_W:0]   lo;
      logic [HI_W-1:0] hi;
      assign lo  = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};
      assign hi  = a[AW-1:LO_W] + b[AW-1:LO_W] + {{(HI_W-1){1'b0}}, lo[LO_W]};
      assign sum = {hi, lo[LO_W-1:0]};
    end else begin : g_flat
      assign sum = a + b;
    end
  endgenerate

endmodule

// File: rtl/dsp_eagen.sv
module dsp_eagen
  import dsp_eagen_pkg::*;
#(
  parameter int          AW       = 24,
  parameter logic [23:0] IO_BASE  = 24'h1FFFC0,
  parameter bit          EA_SPLIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     ptr,
  input  logic [AW-1:0]     nreg,
  input  logic [AW-1:0]     sp,
  input  logic [AW-1:0]     imm,
  output logic              res_vld,
  output logic [AW-1:0]     ea,
  output logic [AW-1:0]     ptr_nxt,
  output logic              ptr_we
);

  logic [AW-1:0] opa, opb, ea_d, nxt_d;
  logic          we_d;

  logic [AW-1:0] ea_q, nxt_q;
  logic          we_q, vld_q;

  dsp_eagen_opsel #(.AW(AW), .IO_BASE(IO_BASE)) u_opsel (
    .mode (mode),
    .ptr  (ptr),
    .sp   (sp),
    .imm  (imm),
    .opa  (opa),
    .opb  (opb)
  );

  dsp_eagen_add #(.AW(AW), .SPLIT(EA_SPLIT)) u_ea_add (
    .a   (opa),
    .b   (opb),
    .sum (ea_d)
  );

  dsp_eagen_postupd #(.AW(AW)) u_upd (
    .mode (mode),
    .ptr  (ptr),
    .nreg (nreg),
    .nxt  (nxt_d),
    .we   (we_d)
  );

  // Result registers, loaded only when a request is present.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      nxt_q <= '0;
      we_q  <= 1'b0;
    end else if (req_vld) begin
      ea_q  <= ea_d;
      nxt_q <= nxt_d;
      we_q  <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= req_vld;
  end

  assign res_vld = vld_q;
  assign ea      = ea_q;
  assign ptr_nxt = nxt_q;
  assign ptr_we  = we_q;

endmodule

// File: rtl/dsp_eagen_chk.sv
module dsp_eagen_chk
  import dsp_eagen_pkg::*;
#(
  parameter int AW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [MODE_W-1:0] mode,
  input logic [AW-1:0]     ptr,
  input logic [AW-1:0]     sp,
  input logic              res_vld,
  input logic [AW-1:0]     ea,
  input logic [AW-1:0]     ptr_nxt,
  input logic              ptr_we
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R12
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (res_vld == $past(req_vld)));

  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(req_vld)) |-> ($stable(ea) && $stable(ptr_nxt) && $stable(ptr_we)));

  // R2
  we_only_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_vld) && ptr_we) |->
      ($past(mode) == AM_PINC || $past(mode) == AM_PDEC || $past(mode) == AM_PUPN));

  // R3
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_vld) && $past(mode) == AM_PINC) |->
      (ptr_we && ea == $past(ptr) && ptr_nxt == $past(ptr) + AW'(1)));

  // R3
  post_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_vld) && $past(mode) == AM_PDEC) |->
      (ptr_we && ea == $past(ptr) && ptr_nxt + AW'(1) == $past(ptr)));

  // R6
  sp_short_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_vld) && $past(mode) == AM_D3SP) |->
      (($past(sp) - ea) >= AW'(1) && ($past(sp) - ea) <= AW'(8)));

  // R7
  sp_long_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_vld) && $past(mode) == AM_D6SP) |->
      (($past(sp) - ea) >= AW'(1) && ($past(sp) - ea) <= AW'(64)));

  // R10
  abs_short_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_vld) && $past(mode) == AM_ABS6) |-> (ea[AW-1:6] == '0));

  // R11
  io_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_vld) && $past(mode) == AM_IOSHRT) |->
      (ea[AW-1:6] == {{(AW-21){1'b0}}, 15'h7FFF}));

endmodule

bind dsp_eagen dsp_eagen_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_vld (req_vld),
  .mode    (mode),
  .ptr     (ptr),
  .sp      (sp),
  .res_vld (res_vld),
  .ea      (ea),
  .ptr_nxt (ptr_nxt),
  .ptr_we  (ptr_we)
);

// File: tb/dsp_eagen_bench.sv
`timescale 1ns/1ps
module dsp_eagen_bench;

  localparam longint MSK = 64'hFFFFFF;

  logic        clk;
  logic        rst_n;
  logic        req_vld;
  logic [3:0]  mode;
  logic [23:0] ptr, nreg, sp, imm;
  logic        res_vld;
  logic [23:0] ea, ptr_nxt;
  logic        ptr_we;

  dsp_eagen u_dsp_eagen (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode(mode),
    .ptr(ptr), .nreg(nreg), .sp(sp), .imm(imm),
    .res_vld(res_vld), .ea(ea), .ptr_nxt(ptr_nxt), .ptr_we(ptr_we)
  );

  typedef struct {
    logic [23:0] ea;
    logic [23:0] nxt;
    logic        we;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  logic [23:0] last_ea, last_nxt;
  logic        last_we;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model written from the requirements.
  function automatic exp_t model(input int m, input longint p, input longint n,
                                 input longint s, input longint im, input string tag);
    exp_t   e;
    longint a, d;
    longint nx;
    bit     w;
    a = p; nx = p; w = 0;
    case (m)
      1:  begin nx = p + 1; w = 1; end
      2:  begin nx = p - 1; w = 1; end
      3:  begin nx = p + n; w = 1; end
      4:  a = p + (im & 7);
      5:  a = s - 8 + (im & 7);
      6:  a = s - 64 + (im & 63);
      7:  begin d = im & 64'hFFFF; if (d >= 32768) d = d - 65536; a = p + d; end
      8:  a = p + im;
      9:  a = im & 63;
      10: a = 64'h1FFFC0 + (im & 63);
      11: a = im & 64'hFFFF;
      12: a = im;
      default: a = p;
    endcase
    e.ea  = 24'(a & MSK);
    e.nxt = 24'(nx & MSK);
    e.we  = w;
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic issue(input int m, input logic [23:0] p, input logic [23:0] n,
                       input logic [23:0] s, input logic [23:0] im, input string tag);
    @(negedge clk);
    req_vld = 1'b1;
    mode    = 4'(m);
    ptr = p; nreg = n; sp = s; imm = im;
    exp_q.push_back(model(m, longint'(p), longint'(n), longint'(s), longint'(im), tag));
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0;
    ptr = 24'hABCDEF; imm = 24'h123456; mode = 4'd1;
  endtask

  // Monitor: pops one expectation per valid result.
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(ea == e.ea && ptr_nxt == e.nxt && ptr_we == e.we, e.tag,
              "ea/ptr_nxt/we", {ea, ptr_nxt, 7'd0, ptr_we},
              {e.ea, e.nxt, 7'd0, e.we});
      end
      last_ea = ea; last_nxt = ptr_nxt; last_we = ptr_we;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; mode = '0;
    ptr = '0; nreg = '0; sp = '0; imm = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(res_vld == 0 && ptr_we == 0 && ea == 0 && ptr_nxt == 0, "R1",
          "reset state", {ea, ptr_nxt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_vld == 0 && ea == 0, "R1", "after release", {ea, 7'd0, res_vld}, 0);

    issue(0,  24'h123456, 24'h000010, 24'h008000, 24'h0, "R2");
    issue(1,  24'h00F00F, 24'h0, 24'h0, 24'h0, "R3");
    issue(1,  24'hFFFFFF, 24'h0, 24'h0, 24'h0, "R3");
    issue(2,  24'h000000, 24'h0, 24'h0, 24'h0, "R3");
    issue(2,  24'h400000, 24'h0, 24'h0, 24'h0, "R3");
    issue(3,  24'h001000, 24'h000020, 24'h0, 24'h0, "R4");
    issue(3,  24'hFFFFF0, 24'h000020, 24'h0, 24'h0, "R4");
    issue(3,  24'h000100, 24'hFFFFFF, 24'h0, 24'h0, "R4");
    issue(4,  24'h002000, 24'h0, 24'h0, 24'hFFFFF7, "R5");
    issue(4,  24'hFFFFFE, 24'h0, 24'h0, 24'h000005, "R5");
    issue(5,  24'h0, 24'h0, 24'h003000, 24'h000007, "R6");
    issue(5,  24'h0, 24'h0, 24'h003000, 24'hFFFFF8, "R6");
    issue(5,  24'h0, 24'h0, 24'h000003, 24'h000000, "R6");
    issue(6,  24'h0, 24'h0, 24'h005000, 24'h00003F, "R7");
    issue(6,  24'h0, 24'h0, 24'h005000, 24'hFFFFC0, "R7");
    issue(6,  24'h0, 24'h0, 24'h000010, 24'h000001, "R7");
    issue(7,  24'h010000, 24'h0, 24'h0, 24'h007FFF, "R8");
    issue(7,  24'h010000, 24'h0, 24'h0, 24'h008000, "R8");
    issue(7,  24'h000010, 24'h0, 24'h0, 24'hFFFFF0, "R8");
    issue(8,  24'h800000, 24'h0, 24'h0, 24'h900001, "R9");
    issue(9,  24'h777777, 24'h0, 24'h0, 24'hFFFFEA, "R10");
    issue(11, 24'h777777, 24'h0, 24'h0, 24'hAB8079, "R10");
    issue(12, 24'h777777, 24'h0, 24'h0, 24'hC0FFEE, "R10");
    issue(10, 24'h777777, 24'h0, 24'h0, 24'hFFFF00, "R11");
    issue(10, 24'h777777, 24'h0, 24'h0, 24'h00003F, "R11");
    issue(13, 24'h345678, 24'h1, 24'h2, 24'h3, "R13");
    issue(15, 24'hFEDCBA, 24'h1, 24'h2, 24'h3, "R13");
    issue(1,  24'h0000AA, 24'h0, 24'h0, 24'h0, "R12");
    idle();
    @(negedge clk);
    // R12: no new result and held outputs during an idle cycle
    check(res_vld == 0, "R12", "res_vld idle", res_vld, 0);
    check(ea == last_ea && ptr_nxt == last_nxt && ptr_we == last_we, "R12",
          "hold", {ea, ptr_nxt}, {last_ea, last_nxt});
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R12", "results outstanding", exp_q.size(), 0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule